// File: doc/BRIEF.md
# Segment Address Extension Unit

The unit widens 32-bit logical addresses into 36-bit physical addresses. A bank of programmable segment entries does the mapping. Each entry holds a logical base, a physical base, a size code and a six-bit permission field. A lookup presents an address, an access type and a privilege level. The unit answers in the same cycle with the physical address, a hit flag and a permission fault.

Segments may overlap. Where they do, the entry with the larger index decides the result. This makes it cheap to cut a private window out of a wide shared mapping, or to close off a region by covering it with an entry that has no permissions. Entries are loaded one whole entry at a time through a write port. After reset the bank already holds an identity map for the lower logical half and a relocated map for the upper half.

Top module: `seg_xlate`

## Requirements
- R1: After reset, entry 0 maps any logical address with bit 31 clear to the same value with four zero bits prepended, with full permissions.
- R2: After reset, entry 1 maps any logical address with bit 31 set to physical 0x8_8000_0000 plus the offset above 0x8000_0000, with full permissions. Entries 2 and up are disabled.
- R3: A segment with size code s spans 2^s bytes, so code 0x1E is 1 GB. It matches when the logical address and its logical base agree in bits 31 down to s. A code below MIN_SIZE (12) disables the entry.
- R4: On a hit, the physical address takes bits 35..s from the physical base and bits s-1..0 from the logical address.
- R5: When several entries match, the entry with the highest index supplies the translation and the permission.
- R6: When no entry matches, hit_o is 0, pa_o is 0 and fault_o is 0.
- R7: Permission bits are: bit 0 user read, bit 1 user write, bit 2 user execute, bit 3 supervisor read, bit 4 supervisor write, bit 5 supervisor execute. acc_i encodes 0 = read, 1 = write, 2 = execute. sup_i = 1 selects the supervisor bits. On a hit, fault_o is 1 exactly when the selected bit is 0. A fault does not change pa_o or hit_o.
- R8: A permission field of 0 faults every access that hits. A field of 0x3F never faults for access codes 0 to 2.
- R9: Access code 3 is reserved and faults on every hit.
- R10: A write with wr_en_i at a rising edge replaces entry wr_idx_i. The new entry is used from the next cycle, and all other entries keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, loads the default entries |
| wr_en_i | input | 1 | Write one entry |
| wr_idx_i | input | 4 | Index of the entry written |
| wr_lbase_i | input | 32 | Logical base for the entry |
| wr_pbase_i | input | 36 | Physical base for the entry |
| wr_size_i | input | 5 | Size code (segment is 2^code bytes) |
| wr_perm_i | input | 6 | Permission bits |
| la_i | input | 32 | Logical address to translate |
| acc_i | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| sup_i | input | 1 | Supervisor privilege |
| pa_o | output | 36 | Physical address, 0 on a miss |
| hit_o | output | 1 | Some enabled entry matches |
| fault_o | output | 1 | Hit whose selected permission bit is clear |

## Verification
The bench builds the unit with its defaults: 16 entries, a minimum size code of 12, 32-bit logical and 36-bit physical addresses. With 16 entries, the random phase can stack many overlapping windows of mixed sizes. That exercises priority resolution across the whole index range and not only between two entries. A minimum code of 12 leaves codes 0 to 11 to test the disable path, while codes from 12 to 31 cover segments from 4 KB up to a full 2 GB half.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int LA_W   = 32;
    localparam int PA_W   = 36;
    localparam int SZ_W   = 5;
    localparam int PERM_W = 6;

    localparam logic [SZ_W-1:0]   SZ_HALF   = 5'd31;
    localparam logic [PERM_W-1:0] PERM_ALL  = 6'h3F;
    localparam logic [LA_W-1:0]   HI_LBASE  = 32'h8000_0000;
    localparam logic [PA_W-1:0]   HI_PBASE  = 36'h8_8000_0000;

    // permission bit positions
    localparam int PB_UR = 0;
    localparam int PB_UW = 1;
    localparam int PB_UX = 2;
    localparam int PB_SR = 3;
    localparam int PB_SW = 4;
    localparam int PB_SX = 5;

    typedef enum logic [1:0] {
        ACC_RD  = 2'd0,
        ACC_WR  = 2'd1,
        ACC_EX  = 2'd2,
        ACC_RSV = 2'd3
    } acc_e;

    typedef struct packed {
        logic [LA_W-1:0]   lbase;
        logic [PA_W-1:0]   pbase;
        logic [SZ_W-1:0]   size;
        logic [PERM_W-1:0] perm;
    } seg_ent_t;

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
    import seg_xlate_pkg::*;
#(
    parameter int NUM_SEG = 16,
    localparam int IDX_W  = $clog2(NUM_SEG)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en_i,
    input  logic [IDX_W-1:0]             wr_idx_i,
    input  seg_ent_t                     wr_ent_i,
    output seg_ent_t [NUM_SEG-1:0]       ents_o
);

    typedef struct packed {
        seg_ent_t [NUM_SEG-1:0] ent;
    } rf_state_t;

    rf_state_t st_d, st_q;

    function automatic rf_state_t rf_reset();
        rf_state_t r;
        r = '0;
        r.ent[0].lbase = '0;
        r.ent[0].pbase = '0;
        r.ent[0].size  = SZ_HALF;
        r.ent[0].perm  = PERM_ALL;
        r.ent[1].lbase = HI_LBASE;
        r.ent[1].pbase = HI_PBASE;
        r.ent[1].size  = SZ_HALF;
        r.ent[1].perm  = PERM_ALL;
        return r;
    endfunction

    always_comb begin
        st_d = st_q;
        if (wr_en_i && (int'(wr_idx_i) < NUM_SEG)) begin
            st_d.ent[wr_idx_i] = wr_ent_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= rf_reset();
        else        st_q <= st_d;
    end

    assign ents_o = st_q.ent;

    // R10: a write lands in the addressed entry
    p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> st_q.ent[$past(wr_idx_i)] == $past(wr_ent_i));

    // R10: without a write the bank holds its contents
    p_bank_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(st_q));

endmodule

// File: rtl/seg_match.sv
module seg_match
    import seg_xlate_pkg::*;
#(
    parameter int NUM_SEG  = 16,
    parameter int MIN_SIZE = 12
) (
    input  logic [LA_W-1:0]                  la_i,
    input  seg_ent_t [NUM_SEG-1:0]           ents_i,
    output logic [NUM_SEG-1:0]               hit_vec_o,
    output logic [NUM_SEG-1:0][PA_W-1:0]     pa_vec_o
);

    localparam int XW = PA_W - LA_W;

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        logic [LA_W-1:0] keep;
        logic            enabled;

        always_comb begin
            keep    = {LA_W{1'b1}} << ents_i[g].size;
            enabled = (int'(ents_i[g].size) >= MIN_SIZE);
            hit_vec_o[g] = enabled && (((la_i ^ ents_i[g].lbase) & keep) == '0);
            pa_vec_o[g]  = {ents_i[g].pbase[PA_W-1:LA_W],
                            (ents_i[g].pbase[LA_W-1:0] & keep) | (la_i & ~keep)};
        end
    end

    // keep the extension width referenced for parameter sanity
    initial begin
        if (XW < 0) $error("physical width narrower than logical width");
    end

endmodule

// File: rtl/seg_prio_sel.sv
module seg_prio_sel
    import seg_xlate_pkg::*;
#(
    parameter int NUM_SEG = 16,
    localparam int IDX_W  = $clog2(NUM_SEG)
) (
    input  logic [NUM_SEG-1:0]               hit_vec_i,
    input  logic [NUM_SEG-1:0][PA_W-1:0]     pa_vec_i,
    input  seg_ent_t [NUM_SEG-1:0]           ents_i,
    input  logic [1:0]                       acc_i,
    input  logic                             sup_i,
    output logic [IDX_W-1:0]                 win_o,
    output logic [PA_W-1:0]                  pa_o,
    output logic                             hit_o,
    output logic                             fault_o
);

    logic [PERM_W-1:0] perm;
    logic              allowed;

    always_comb begin
        hit_o = 1'b0;
        win_o = '0;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (hit_vec_i[i]) begin
                hit_o = 1'b1;
                win_o = IDX_W'(i);
            end
        end

        perm = ents_i[win_o].perm;
        unique case (acc_e'(acc_i))
            ACC_RD:  allowed = sup_i ? perm[PB_SR] : perm[PB_UR];
            ACC_WR:  allowed = sup_i ? perm[PB_SW] : perm[PB_UW];
            ACC_EX:  allowed = sup_i ? perm[PB_SX] : perm[PB_UX];
            default: allowed = 1'b0;
        endcase

        pa_o    = hit_o ? pa_vec_i[win_o] : '0;
        fault_o = hit_o && !allowed;
    end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int NUM_SEG  = 16,
    parameter int MIN_SIZE = 12,
    localparam int IDX_W   = $clog2(NUM_SEG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [LA_W-1:0]   wr_lbase_i,
    input  logic [PA_W-1:0]   wr_pbase_i,
    input  logic [SZ_W-1:0]   wr_size_i,
    input  logic [PERM_W-1:0] wr_perm_i,
    input  logic [LA_W-1:0]   la_i,
    input  logic [1:0]        acc_i,
    input  logic              sup_i,
    output logic [PA_W-1:0]   pa_o,
    output logic              hit_o,
    output logic              fault_o
);

    seg_ent_t                     wr_ent;
    seg_ent_t [NUM_SEG-1:0]       ents;
    logic [NUM_SEG-1:0]           hit_vec;
    logic [NUM_SEG-1:0][PA_W-1:0] pa_vec;
    logic [IDX_W-1:0]             win;

    assign wr_ent = '{lbase: wr_lbase_i, pbase: wr_pbase_i,
                      size: wr_size_i, perm: wr_perm_i};

    seg_regfile #(.NUM_SEG(NUM_SEG)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en_i),
        .wr_idx_i (wr_idx_i),
        .wr_ent_i (wr_ent),
        .ents_o   (ents)
    );

    seg_match #(.NUM_SEG(NUM_SEG), .MIN_SIZE(MIN_SIZE)) u_match (
        .la_i      (la_i),
        .ents_i    (ents),
        .hit_vec_o (hit_vec),
        .pa_vec_o  (pa_vec)
    );

    seg_prio_sel #(.NUM_SEG(NUM_SEG)) u_sel (
        .hit_vec_i (hit_vec),
        .pa_vec_i  (pa_vec),
        .ents_i    (ents),
        .acc_i     (acc_i),
        .sup_i     (sup_i),
        .win_o     (win),
        .pa_o      (pa_o),
        .hit_o     (hit_o),
        .fault_o   (fault_o)
    );

    // R5: the winner matches and no higher entry matches
    p_highest_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (hit_vec[win] && (((hit_vec >> win) >> 1) == '0)));

    // R6: a miss is silent
    p_miss_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (pa_o == '0 && !fault_o));

    // R4: the low page offset always passes through
    p_offset_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (pa_o[MIN_SIZE-1:0] == la_i[MIN_SIZE-1:0]));

    // R8: an entry without permissions always faults
    p_zero_perm_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && ents[win].perm == '0) |-> fault_o);

    // R9: reserved access code always faults on a hit
    p_rsv_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && acc_i == 2'd3) |-> fault_o);

endmodule

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;

    localparam int NS = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [3:0]  wr_idx_i = '0;
    logic [31:0] wr_lbase_i = '0;
    logic [35:0] wr_pbase_i = '0;
    logic [4:0]  wr_size_i = '0;
    logic [5:0]  wr_perm_i = '0;
    logic [31:0] la_i = '0;
    logic [1:0]  acc_i = '0;
    logic        sup_i = 1'b0;
    logic [35:0] pa_o;
    logic        hit_o;
    logic        fault_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_lb [NS];
    logic [35:0] m_pb [NS];
    logic [4:0]  m_sz [NS];
    logic [5:0]  m_pm [NS];

    always #2 clk = ~clk;

    seg_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i),
        .wr_lbase_i(wr_lbase_i), .wr_pbase_i(wr_pbase_i), .wr_size_i(wr_size_i),
        .wr_perm_i(wr_perm_i), .la_i(la_i), .acc_i(acc_i), .sup_i(sup_i),
        .pa_o(pa_o), .hit_o(hit_o), .fault_o(fault_o)
    );

    function automatic void model(input logic [31:0] la, input logic [1:0] acc,
                                  input logic sup, output logic [35:0] epa,
                                  output logic eh, output logic ef);
        epa = '0; eh = 1'b0; ef = 1'b0;
        for (int i = NS - 1; i >= 0; i--) begin
            if (!eh && m_sz[i] >= 5'd12 &&
                ((la >> m_sz[i]) == (m_lb[i] >> m_sz[i]))) begin
                eh  = 1'b1;
                epa = ((m_pb[i] >> m_sz[i]) << m_sz[i]) +
                      36'(la & ((32'h1 << m_sz[i]) - 32'h1));
                if (acc == 2'd3) ef = 1'b1;
                else             ef = !m_pm[i][int'(sup) * 3 + int'(acc)];
            end
        end
    endfunction

    task automatic wr(input int idx, input logic [31:0] lb, input logic [35:0] pb,
                      input logic [4:0] sz, input logic [5:0] pm);
        @(negedge clk);
        wr_en_i = 1'b1; wr_idx_i = 4'(idx); wr_lbase_i = lb;
        wr_pbase_i = pb; wr_size_i = sz; wr_perm_i = pm;
        @(negedge clk);
        wr_en_i = 1'b0;
        m_lb[idx] = lb; m_pb[idx] = pb; m_sz[idx] = sz; m_pm[idx] = pm;
    endtask

    task automatic chk(input logic [31:0] la, input logic [1:0] acc, input logic sup,
                       input string tag);
        logic [35:0] epa;
        logic eh, ef;
        @(negedge clk);
        la_i = la; acc_i = acc; sup_i = sup;
        #1;
        model(la, acc, sup, epa, eh, ef);
        checks++;
        if (pa_o !== epa || hit_o !== eh || fault_o !== ef) begin
            errors++;
            $display("FAIL %s la=%h acc=%0d sup=%0d: got pa=%h hit=%b fault=%b exp pa=%h hit=%b fault=%b",
                     tag, la, acc, sup, pa_o, hit_o, fault_o, epa, eh, ef);
        end
    endtask

    task automatic chk_const(input logic [31:0] la, input logic [35:0] epa,
                             input logic eh, input logic ef, input string tag);
        @(negedge clk);
        la_i = la; acc_i = 2'd0; sup_i = 1'b0;
        #1;
        checks++;
        if (pa_o !== epa || hit_o !== eh || fault_o !== ef) begin
            errors++;
            $display("FAIL %s la=%h: got pa=%h hit=%b fault=%b exp pa=%h hit=%b fault=%b",
                     tag, la, pa_o, hit_o, fault_o, epa, eh, ef);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7305));
        for (int i = 0; i < NS; i++) begin
            m_lb[i] = '0; m_pb[i] = '0; m_sz[i] = '0; m_pm[i] = '0;
        end
        m_sz[0] = 5'd31; m_pm[0] = 6'h3F;
        m_lb[1] = 32'h8000_0000; m_pb[1] = 36'h8_8000_0000;
        m_sz[1] = 5'd31; m_pm[1] = 6'h3F;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R2: reset mapping, checked against fixed constants
        chk_const(32'h1234_5678, 36'h0_1234_5678, 1'b1, 1'b0, "R1");
        chk_const(32'h0000_0000, 36'h0_0000_0000, 1'b1, 1'b0, "R1");
        chk_const(32'h9000_0010, 36'h8_9000_0010, 1'b1, 1'b0, "R2");
        chk_const(32'hFFFF_FFFF, 36'h8_FFFF_FFFF, 1'b1, 1'b0, "R2");
        chk(32'h7FFF_FFFF, 2'd2, 1'b1, "R1");

        // R3 / R7: 1 GB window, user read only
        wr(5, 32'h4000_0000, 36'h9_0000_0000, 5'h1E, 6'b000001);
        chk_const(32'h4000_1234, 36'h9_0000_1234, 1'b1, 1'b0, "R3");
        chk_const(32'h7FFF_FFFC, 36'h9_3FFF_FFFC, 1'b1, 1'b0, "R4");
        chk(32'h4000_1234, 2'd1, 1'b0, "R7");
        chk(32'h4000_1234, 2'd0, 1'b1, "R7");
        chk(32'h4000_1234, 2'd2, 1'b0, "R7");

        // R5: higher entry carves a window out of entry 5
        wr(9, 32'h4800_0000, 36'h3_1000_0000, 5'd24, 6'h3F);
        chk_const(32'h4812_3456, 36'h3_1012_3456, 1'b1, 1'b0, "R5");
        chk(32'h4812_3456, 2'd1, 1'b1, "R5");
        chk(32'h4000_0000, 2'd1, 1'b0, "R5");

        // R8: zero permission window
        wr(12, 32'h4900_0000, 36'h0_0000_0000, 5'd24, 6'h00);
        for (int a = 0; a < 4; a++) begin
            chk(32'h4900_0040, 2'(a), 1'b0, "R8");
            chk(32'h4900_0040, 2'(a), 1'b1, "R8");
        end

        // R9: reserved access on a full-permission entry
        chk(32'h0000_1000, 2'd3, 1'b0, "R9");
        chk(32'h0000_1000, 2'd3, 1'b1, "R9");

        // R10: rewriting entry 9 leaves entries 5 and 1 alone
        wr(9, 32'h4800_0000, 36'h5_5500_0000, 5'd24, 6'b111000);
        chk_const(32'h48AB_CDEF, 36'h5_55AB_CDEF, 1'b1, 1'b1, "R10");
        chk(32'h4000_0008, 2'd0, 1'b0, "R10");
        chk_const(32'hA000_0000, 36'h8_A000_0000, 1'b1, 1'b0, "R10");

        // R3 / R6: size code below minimum disables, misses are quiet
        wr(0, 32'h0000_0000, 36'h0_0000_0000, 5'd11, 6'h3F);
        chk_const(32'h0000_0100, 36'h0, 1'b0, 1'b0, "R6");
        chk_const(32'h0000_0FFF, 36'h0, 1'b0, 1'b0, "R3");
        wr(1, 32'h8000_0000, 36'h0, 5'd0, 6'h3F);
        chk(32'hC000_0000, 2'd1, 1'b1, "R6");

        // random phase
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 9) == 0) begin
                wr(int'($urandom_range(0, NS - 1)), $urandom,
                   {4'($urandom), 32'($urandom)},
                   5'($urandom_range(12, 31)) - (($urandom_range(0, 15) == 0) ? 5'd12 : 5'd0),
                   6'($urandom));
            end else begin
                logic [31:0] la;
                int k;
                k  = int'($urandom_range(0, NS - 1));
                la = $urandom;
                if ($urandom_range(0, 1) == 1 && m_sz[k] >= 5'd12)
                    la = (m_lb[k] & ~((32'h1 << m_sz[k]) - 32'h1)) |
                         (la & ((32'h1 << m_sz[k]) - 32'h1));
                chk(la, 2'($urandom), 1'($urandom), "R5");
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule